// File: doc/BRIEF.md
# I2C Byte Buffer and Status Flags

This block keeps the byte-level state of an I2C controller. It sits between a one-byte software data register and a bit-level shift engine. When the engine finishes or needs a byte, the block decides where that byte goes. It can go into the data register, be parked in the shift stage, or be lost. It then updates the status flags that software polls. When no byte can move, it raises a byte-transfer-complete flag and asks the engine to hold SCL low until software services the data register.

Error events from the engine latch into sticky flags: acknowledge failure, arbitration loss and a misplaced START or STOP. An arbitration loss also sends a one-cycle pulse that forces the controller back to slave mode. Software clears an error flag by writing 0 to its bit. The stop flag is cleared only by a status read followed by a control-register write.

Top module: `i2c_xfer_flags`

## Requirements
- R1: After reset the status word is 0, `sclHold` is 0, `txLoad` is 0 and `forceSlave` is 0.
- R2: In receive mode, a finished byte with `rxFull` (bit 6) clear is placed in the data register and sets `rxFull`. A data read while `byteWait` (bit 2) is clear clears `rxFull`.
- R3: In receive mode, a finished byte that arrives while `rxFull` is set is parked when stretching is enabled or the block is master. Parking sets `byteWait` and `sclHold`. The next data read moves the parked byte into the data register, keeps `rxFull` set and clears `byteWait`.
- R4: In slave receive with stretching disabled, a finished byte that arrives while `rxFull` is set sets `xrunErr` (bit 11). That byte is dropped, the data register keeps its old byte and `byteWait` stays 0.
- R5: In transmit mode, a data write into an empty buffer clears `txEmpty` (bit 7). The next byte-needed event pulses `txLoad` for one cycle with that byte on `txByte` and sets `txEmpty`.
- R6: In transmit mode with stretching enabled, a byte-needed event with no byte buffered sets `txEmpty`, `byteWait` and `sclHold`. The next data write goes straight to the shifter: `txLoad` pulses with the written byte, `txEmpty` stays 1 and `byteWait` clears.
- R7: In slave transmit with stretching disabled, a byte-needed event with no byte buffered sets `xrunErr`. In that case no `txLoad` pulse occurs and `byteWait` stays 0.
- R8: Each engine event sets its sticky flag: acknowledge failure sets bit 10, arbitration loss sets bit 9 and bus error sets bit 8. A status write clears each of bits 8 to 11 whose written bit is 0 and leaves it alone where the written bit is 1. A set event in the same cycle as a clear wins.
- R9: An arbitration-loss event sets bit 9 and pulses `forceSlave` for exactly the following cycle.
- R10: A STOP seen in slave mode sets `stopSeen` (bit 4). A STOP seen in master mode has no effect. `stopSeen` clears only on a control write that comes after a status read made while it was set. A control write alone, or a status write, leaves it set.
- R11: Status bits 15..12, 5, 3, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeMaster | input | 1 | 1 = master, 0 = slave |
| modeTx | input | 1 | 1 = transmit, 0 = receive |
| stretchOff | input | 1 | 1 = clock stretching disabled |
| engByteDone | input | 1 | Shift engine finished receiving a byte |
| engRxByte | input | 8 | Byte received by the engine |
| engByteNeed | input | 1 | Shift engine needs the next byte to send |
| evAckFail | input | 1 | Acknowledge failure event |
| evArbLost | input | 1 | Arbitration loss event |
| evBusErr | input | 1 | Misplaced START/STOP event |
| evStopSeen | input | 1 | STOP condition seen on the bus |
| swDataWr | input | 1 | Software data-register write strobe |
| swWrData | input | 8 | Software write byte |
| swDataRd | input | 1 | Software data-register read strobe |
| swStatRd | input | 1 | Software status read strobe |
| swStatWr | input | 1 | Software status write strobe |
| swStatWrData | input | 16 | Status write value (0 clears an error bit) |
| swCtlWr | input | 1 | Software control-register write strobe |
| rdData | output | 8 | Data register contents |
| statusWord | output | 16 | Status flags |
| txByte | output | 8 | Byte handed to the shifter |
| txLoad | output | 1 | One-cycle pulse: `txByte` is valid for the shifter |
| sclHold | output | 1 | Request to hold SCL low |
| forceSlave | output | 1 | One-cycle pulse forcing slave mode |

## Verification
The bench goes after the hand-across cases. A design that cleared `rxFull` on a read while a byte was parked would lose that byte and report an empty buffer. A design that cleared `txEmpty` on a write straight to the shifter would wait for a byte that never comes. It sweeps byte values and every master/slave and stretch combination across the overrun and underrun conditions, so an error flag raised in master mode or with stretching enabled is caught. It also tries a set and a clear in the same cycle, a write of 1 to each error bit, and control writes with and without a prior status read. A wrong priority would lose an error, and a one-step stop clear would drop the stop flag early.

// File: rtl/i2c_buf_pkg.sv
package i2c_buf_pkg;

  localparam int STAT_W   = 16;
  localparam int BIT_XRUN = 11;
  localparam int BIT_ACK  = 10;
  localparam int BIT_ARB  = 9;
  localparam int BIT_BUS  = 8;
  localparam int BIT_TXE  = 7;
  localparam int BIT_RXF  = 6;
  localparam int BIT_STOP = 4;
  localparam int BIT_WAIT = 2;
  localparam int N_ERR    = 4;

  typedef struct packed {
    logic rxToData;
    logic rxToHold;
    logic holdToData;
    logic swToData;
    logic swToShift;
    logic dataToShift;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_buf_ctrl.sv
module i2c_buf_ctrl
  import i2c_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeMaster,
  input  logic              modeTx,
  input  logic              stretchOff,
  input  logic              engByteDone,
  input  logic              engByteNeed,
  input  logic              evAckFail,
  input  logic              evArbLost,
  input  logic              evBusErr,
  input  logic              evStopSeen,
  input  logic              swDataWr,
  input  logic              swDataRd,
  input  logic              swStatRd,
  input  logic              swStatWr,
  input  logic [STAT_W-1:0] swStatWrData,
  input  logic              swCtlWr,
  output dpStrobe_t         strb,
  output logic [STAT_W-1:0] statusWord,
  output logic              sclHold,
  output logic              forceSlave
);

  logic rxFull, rxFullN;
  logic txEmpty, txEmptyN;
  logic txFull, txFullN;
  logic byteWait, byteWaitN;
  logic stopSeen, stopArm;
  logic xrunSet;
  logic slaveNoStretch;

  // error flags: index 3 = xrun, 2 = ack, 1 = arb, 0 = bus
  logic [N_ERR-1:0] errFlags, errSet, errClr;

  assign slaveNoStretch = !modeMaster && stretchOff;

  always_comb begin
    logic rxMid;
    logic txFullMid, waitMid;
    strb      = '0;
    rxFullN   = rxFull;
    txEmptyN  = txEmpty;
    txFullN   = txFull;
    byteWaitN = byteWait;
    xrunSet   = 1'b0;
    rxMid     = rxFull;
    txFullMid = txFull;
    waitMid   = byteWait;
    if (!modeTx) begin
      if (swDataRd && rxFull) begin
        if (byteWait) begin
          strb.holdToData = 1'b1;
          waitMid         = 1'b0;
        end else begin
          rxMid = 1'b0;
        end
      end
      if (engByteDone) begin
        if (!rxMid) begin
          strb.rxToData = 1'b1;
          rxMid         = 1'b1;
        end else if (slaveNoStretch) begin
          xrunSet = 1'b1;
        end else begin
          strb.rxToHold = 1'b1;
          waitMid       = 1'b1;
        end
      end
      rxFullN   = rxMid;
      byteWaitN = waitMid;
    end else begin
      if (engByteNeed) begin
        txEmptyN = 1'b1;
        if (txFull) begin
          strb.dataToShift = 1'b1;
          txFullMid        = 1'b0;
        end else if (slaveNoStretch) begin
          xrunSet = 1'b1;
        end else begin
          waitMid = 1'b1;
        end
      end
      if (swDataWr) begin
        if (waitMid) begin
          strb.swToShift = 1'b1;
          waitMid        = 1'b0;
        end else begin
          strb.swToData = 1'b1;
          txEmptyN      = 1'b0;
          txFullMid     = 1'b1;
        end
      end
      txFullN   = txFullMid;
      byteWaitN = waitMid;
    end
  end

  assign errSet = {xrunSet, evAckFail, evArbLost, evBusErr};

  always_comb begin
    errClr = '0;
    if (swStatWr) begin
      errClr = ~{swStatWrData[BIT_XRUN], swStatWrData[BIT_ACK],
                 swStatWrData[BIT_ARB], swStatWrData[BIT_BUS]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxFull     <= 1'b0;
      txEmpty    <= 1'b0;
      txFull     <= 1'b0;
      byteWait   <= 1'b0;
      errFlags   <= '0;
      stopSeen   <= 1'b0;
      stopArm    <= 1'b0;
      forceSlave <= 1'b0;
    end else begin
      rxFull     <= rxFullN;
      txEmpty    <= txEmptyN;
      txFull     <= txFullN;
      byteWait   <= byteWaitN;
      errFlags   <= (errFlags & ~errClr) | errSet;
      forceSlave <= evArbLost;
      if (evStopSeen && !modeMaster) begin
        stopSeen <= 1'b1;
      end else if (swCtlWr && stopArm) begin
        stopSeen <= 1'b0;
      end
      if (swCtlWr) begin
        stopArm <= 1'b0;
      end else if (swStatRd && stopSeen) begin
        stopArm <= 1'b1;
      end
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[BIT_XRUN] = errFlags[3];
    statusWord[BIT_ACK]  = errFlags[2];
    statusWord[BIT_ARB]  = errFlags[1];
    statusWord[BIT_BUS]  = errFlags[0];
    statusWord[BIT_TXE]  = txEmpty;
    statusWord[BIT_RXF]  = rxFull;
    statusWord[BIT_STOP] = stopSeen;
    statusWord[BIT_WAIT] = byteWait;
  end

  assign sclHold = byteWait;

endmodule

// File: rtl/i2c_buf_dp.sv
module i2c_buf_dp
  import i2c_buf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] engRxByte,
  input  logic [DATA_W-1:0] swWrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] txByte,
  output logic              txLoad
);

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataReg <= '0;
      holdReg <= '0;
      txByte  <= '0;
      txLoad  <= 1'b0;
    end else begin
      txLoad <= strb.dataToShift | strb.swToShift;
      if (strb.rxToData) begin
        dataReg <= engRxByte;
      end else if (strb.holdToData) begin
        dataReg <= holdReg;
      end else if (strb.swToData) begin
        dataReg <= swWrData;
      end
      if (strb.rxToHold) begin
        holdReg <= engRxByte;
      end
      if (strb.dataToShift) begin
        txByte <= dataReg;
      end else if (strb.swToShift) begin
        txByte <= swWrData;
      end
    end
  end

  assign rdData = dataReg;

endmodule

// File: rtl/i2c_xfer_flags.sv
module i2c_xfer_flags
  import i2c_buf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeMaster,
  input  logic              modeTx,
  input  logic              stretchOff,
  input  logic              engByteDone,
  input  logic [DATA_W-1:0] engRxByte,
  input  logic              engByteNeed,
  input  logic              evAckFail,
  input  logic              evArbLost,
  input  logic              evBusErr,
  input  logic              evStopSeen,
  input  logic              swDataWr,
  input  logic [DATA_W-1:0] swWrData,
  input  logic              swDataRd,
  input  logic              swStatRd,
  input  logic              swStatWr,
  input  logic [15:0]       swStatWrData,
  input  logic              swCtlWr,
  output logic [DATA_W-1:0] rdData,
  output logic [15:0]       statusWord,
  output logic [DATA_W-1:0] txByte,
  output logic              txLoad,
  output logic              sclHold,
  output logic              forceSlave
);

  dpStrobe_t strb;

  i2c_buf_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .modeMaster(modeMaster), .modeTx(modeTx), .stretchOff(stretchOff),
    .engByteDone(engByteDone), .engByteNeed(engByteNeed),
    .evAckFail(evAckFail), .evArbLost(evArbLost), .evBusErr(evBusErr),
    .evStopSeen(evStopSeen),
    .swDataWr(swDataWr), .swDataRd(swDataRd), .swStatRd(swStatRd),
    .swStatWr(swStatWr), .swStatWrData(swStatWrData), .swCtlWr(swCtlWr),
    .strb(strb), .statusWord(statusWord), .sclHold(sclHold),
    .forceSlave(forceSlave)
  );

  i2c_buf_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .engRxByte(engRxByte), .swWrData(swWrData),
    .rdData(rdData), .txByte(txByte), .txLoad(txLoad)
  );

endmodule

// File: rtl/i2c_xfer_flags_chk.sv
module i2c_xfer_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              modeMaster,
  input logic              modeTx,
  input logic              stretchOff,
  input logic              engByteDone,
  input logic              engByteNeed,
  input logic              evAckFail,
  input logic              evArbLost,
  input logic              evStopSeen,
  input logic              swDataRd,
  input logic              swStatWr,
  input logic [15:0]       statusWord,
  input logic              forceSlave,
  input logic              sclHold
);

  // R11: unused status positions stay 0
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWord[15:12] == 4'd0) && !statusWord[5] && !statusWord[3] &&
    (statusWord[1:0] == 2'd0));

  // R9: arbitration loss forces slave on the next cycle
  a_r9_force_after_arb: assert property (@(posedge clk) disable iff (!rst_n)
    evArbLost |=> forceSlave && statusWord[9]);

  // R8: a set event beats any clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evAckFail |=> statusWord[10]);

  // R10: STOP in master mode cannot raise the flag
  a_r10_master_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (evStopSeen && modeMaster && !statusWord[4]) |=> !statusWord[4]);

  // R2: plain read in receive mode empties the buffer
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeTx && swDataRd && statusWord[6] && !statusWord[2] && !engByteDone)
    |=> !statusWord[6]);

  // R3: a parked receive byte implies the data register is full
  a_r3_wait_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!modeTx && statusWord[2]) |-> statusWord[6]);

  // R3/R6: the hold request follows the wait flag
  a_r6_hold_tracks_wait: assert property (@(posedge clk) disable iff (!rst_n)
    sclHold == statusWord[2]);

endmodule

bind i2c_xfer_flags i2c_xfer_flags_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .modeMaster(modeMaster), .modeTx(modeTx),
  .stretchOff(stretchOff), .engByteDone(engByteDone), .engByteNeed(engByteNeed),
  .evAckFail(evAckFail), .evArbLost(evArbLost), .evStopSeen(evStopSeen),
  .swDataRd(swDataRd), .swStatWr(swStatWr), .statusWord(statusWord),
  .forceSlave(forceSlave), .sclHold(sclHold)
);

// File: tb/i2c_xfer_flags_tb.sv
module i2c_xfer_flags_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modeMaster = 0, modeTx = 0, stretchOff = 0;
  logic engByteDone = 0, engByteNeed = 0;
  logic [7:0] engRxByte = 0;
  logic evAckFail = 0, evArbLost = 0, evBusErr = 0, evStopSeen = 0;
  logic swDataWr = 0, swDataRd = 0, swStatRd = 0, swStatWr = 0, swCtlWr = 0;
  logic [7:0] swWrData = 0;
  logic [15:0] swStatWrData = 0;
  logic [7:0] rdData, txByte;
  logic [15:0] statusWord;
  logic txLoad, sclHold, forceSlave;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_xfer_flags dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clrIn();
    engByteDone = 0; engByteNeed = 0; evAckFail = 0; evArbLost = 0;
    evBusErr = 0; evStopSeen = 0; swDataWr = 0; swDataRd = 0;
    swStatRd = 0; swStatWr = 0; swCtlWr = 0;
  endtask

  // inputs set at a falling edge, held over one rising edge, cleared next fall
  task automatic tick();
    @(negedge clk);
    clrIn();
  endtask

  task automatic doReset();
    clrIn();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #900000;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    doReset();
    // R1: reset state
    chk("R1 status", statusWord, 16'h0000);
    chk("R1 outs", {13'd0, sclHold, txLoad, forceSlave}, 16'h0000);

    // receive path, stretching on, both roles
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] b1, b2;
        b1 = 8'(i * 37 + 5);
        b2 = ~b1;
        doReset();
        modeMaster = m[0]; modeTx = 0; stretchOff = 0;
        engByteDone = 1; engRxByte = b1; tick();
        chk("R2 rxFull set", statusWord, 16'h0040);
        chk("R2 data", {8'd0, rdData}, {8'd0, b1});
        engByteDone = 1; engRxByte = b2; tick();
        chk("R3 parked", statusWord, 16'h0044);
        chk("R3 hold", {15'd0, sclHold}, 16'd1);
        chk("R3 data kept", {8'd0, rdData}, {8'd0, b1});
        swDataRd = 1; tick();
        chk("R3 moved", statusWord, 16'h0040);
        chk("R3 new data", {8'd0, rdData}, {8'd0, b2});
        swDataRd = 1; tick();
        chk("R2 read clears", statusWord, 16'h0000);
      end
    end

    // overrun sweep: all role/stretch combos, R4 only in slave+off
    for (int c = 0; c < 4; c++) begin
      doReset();
      modeMaster = c[0]; stretchOff = c[1]; modeTx = 0;
      engByteDone = 1; engRxByte = 8'h3C; tick();
      engByteDone = 1; engRxByte = 8'hC3; tick();
      if (!c[0] && c[1]) begin
        chk("R4 overrun", statusWord, 16'h0840);
        chk("R4 data kept", {8'd0, rdData}, 16'h003C);
        swStatWr = 1; swStatWrData = 16'hF7FF; tick();
        chk("R8 clear xrun", statusWord, 16'h0040);
      end else begin
        chk("R4 no overrun", statusWord, 16'h0044);
      end
    end

    // transmit path sweep
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] b1, b2;
        b1 = 8'(i * 53 + 9);
        b2 = b1 ^ 8'h5A;
        doReset();
        modeMaster = m[0]; modeTx = 1; stretchOff = 0;
        swDataWr = 1; swWrData = b1; tick();
        chk("R5 txEmpty clear", statusWord, 16'h0000);
        engByteNeed = 1; tick();
        chk("R5 load", {7'd0, txLoad, txByte}, {7'd0, 1'b1, b1});
        chk("R5 txEmpty set", statusWord, 16'h0080);
        engByteNeed = 1; tick();
        chk("R6 wait", statusWord, 16'h0084);
        chk("R6 no load", {15'd0, txLoad}, 16'd0);
        chk("R6 hold", {15'd0, sclHold}, 16'd1);
        swDataWr = 1; swWrData = b2; tick();
        chk("R6 straight load", {7'd0, txLoad, txByte}, {7'd0, 1'b1, b2});
        chk("R6 txEmpty stays", statusWord, 16'h0080);
      end
    end

    // underrun sweep
    for (int c = 0; c < 4; c++) begin
      doReset();
      modeMaster = c[0]; stretchOff = c[1]; modeTx = 1;
      engByteNeed = 1; tick();
      chk("R7 no load", {15'd0, txLoad}, 16'd0);
      if (!c[0] && c[1]) chk("R7 underrun", statusWord, 16'h0880);
      else chk("R7 no underrun", statusWord, 16'h0084);
    end

    // sticky error flags
    doReset();
    modeMaster = 1; modeTx = 0; stretchOff = 0;
    for (int k = 0; k < 3; k++) begin
      logic [15:0] bitm;
      bitm = 16'h0100 << k;
      if (k == 0) evBusErr = 1; else if (k == 1) evArbLost = 1; else evAckFail = 1;
      tick();
      chk("R8 set", statusWord, bitm);
      if (k == 1) chk("R9 force pulse", {15'd0, forceSlave}, 16'd1);
      tick();
      if (k == 1) chk("R9 pulse ends", {15'd0, forceSlave}, 16'd0);
      swStatWr = 1; swStatWrData = 16'hFFFF; tick();
      chk("R8 write1 keeps", statusWord, bitm);
      swStatWr = 1; swStatWrData = ~bitm;
      if (k == 0) evBusErr = 1; else if (k == 1) evArbLost = 1; else evAckFail = 1;
      tick();
      chk("R8 set wins", statusWord, bitm);
      swStatWr = 1; swStatWrData = ~bitm; tick();
      chk("R8 write0 clears", statusWord, 16'h0000);
    end

    // stop flag
    doReset();
    modeMaster = 1; evStopSeen = 1; tick();
    chk("R10 master ignored", statusWord, 16'h0000);
    modeMaster = 0; evStopSeen = 1; tick();
    chk("R10 slave set", statusWord, 16'h0010);
    swCtlWr = 1; tick();
    chk("R10 ctl alone keeps", statusWord, 16'h0010);
    swStatWr = 1; swStatWrData = 16'h0000; tick();
    chk("R10 stat write keeps", statusWord, 16'h0010);
    swStatRd = 1; tick();
    chk("R10 after read", statusWord, 16'h0010);
    swCtlWr = 1; tick();
    chk("R10 cleared", statusWord, 16'h0000);
    chk("R11 reserved", statusWord & 16'hF02B, 16'h0000);

    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule